// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel

A single DMA channel that moves 32-bit words according to a transfer descriptor held in memory. Software points the channel at a descriptor and pulses a load strobe. The channel then reads five consecutive words: source address, destination address, an offsets-and-burst word, a control word and a next-descriptor address. After that it checks the descriptor and either runs it or rejects it.

Data moves in minor loops. Each minor loop is a burst of read-then-write word pairs. After each access the source address and the destination address step by their own signed byte offset. An offset of 0 keeps an address fixed on a peripheral data port; an offset of 4 walks through memory. A 15-bit major count sets how many minor loops make up the job. A channel flagged for software start runs all its minor loops back to back. Any other channel waits for one hardware request per minor loop, and requests only count while its request enable is set. When the major count runs out, the channel can optionally drop its request enable and optionally chain to the next descriptor. Memory errors and rejected descriptors stop the channel until software clears them.

Top module: `dma_chan_engine`

## Requirements
- R1: While reset is applied and just after it, `mem_req`, `done`, `err`, `req_en` and `active` are 0, and `iter_left` is 0.
- R2: A `load` pulse, when the channel is idle or waiting for requests, reads five words at `load_addr`+0, +4, +8, +12 and +16 in that order, and clears `done`.
  - Word 2 is laid out as: bits [7:0] source offset, bits [15:8] destination offset, bits [23:16] burst in words.
  - Word 3 is laid out as: bits [8:0] low count, bits [14:9] high count, bit 15 chain, bit 16 drop-enable, bit 17 software start.
  - After an accepted load, `iter_left` equals the 15-bit count.
- R3: After each word is read, the source address steps by the sign-extended 8-bit source offset. After each word is written, the destination address steps by the destination offset. An offset of 0 repeats the same address.
- R4: A minor loop is a burst of read-then-write word pairs, and the write carries the data just read. A burst field of 0 means 16 words. `iter_left` drops by one only at the end of a minor loop.
- R5: When the last minor loop of the major count ends, `done` goes to 1 and `iter_left` reloads to the full count.
- R6: With the software-start bit set, all minor loops run without any request.
- R7: With the software-start bit clear, each accepted `req` pulse runs one minor loop. A `req` while `req_en` is 0 causes no memory access. `req_en_set` and `req_en_clr` control `req_en`, and clear wins.
- R8: A request that arrives during a minor loop is held (at most one) and served when that loop ends.
- R9: With the drop-enable bit set, `req_en` goes to 0 when the major count completes. With the bit clear, `req_en` stays 1.
- R10: With the chain bit set, completion fetches the next descriptor from the address in word 4. With the bit clear, the channel stops after completion.
- R11: A descriptor is rejected if its source address, destination address or either offset is not a multiple of 4, or if its count is 0. A rejected descriptor makes no data access, and it sets `err` with `err_addr` equal to the descriptor address.
- R12: `mem_err` on any access stops the channel and sets `err` with `err_addr` equal to the failing address. While `err` is 1 there is no memory access and `load` is ignored. `err_clr` returns `err` and `err_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Pulse: fetch descriptor at load_addr |
| load_addr | input | AW | Descriptor address |
| req_en_set | input | 1 | Pulse: set request enable |
| req_en_clr | input | 1 | Pulse: clear request enable |
| req | input | 1 | Peripheral service request pulse |
| err_clr | input | 1 | Pulse: clear error and restart |
| mem_req | output | 1 | Memory access request, held until ack or error |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| active | output | 1 | Fetching, checking or moving data |
| done | output | 1 | Sticky major-loop completion flag |
| err | output | 1 | Channel halted on error |
| err_addr | output | AW | Address that caused the error |
| req_en | output | 1 | Hardware request enable |
| iter_left | output | 15 | Current major iteration count |

## Verification
The bench builds the channel with its default parameters: a 32-bit address and a 16-word default burst. The zero burst field therefore takes the 16-word path. A count of 513 places a 1 in both the low and the high count field. The memory responder inserts wait states and reports an error at one fixed address, and a peripheral port sits outside the array: reads there return a running counter and writes there are checked against the reference model. Together these cover fixed, rising and falling addresses, chained descriptors, paced and pending requests, rejection and mid-burst bus errors.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW        = 32,
  parameter int DEF_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          req_en_set,
  input  logic          req_en_clr,
  input  logic          req,
  input  logic          err_clr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          active,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] err_addr,
  output logic          req_en,
  output logic [14:0]   iter_left
);
  localparam logic [7:0] DEFW = 8'(DEF_WORDS);

  typedef enum logic [2:0] {IDLE, FETCH, CHECK, ARMED, RD, WR, HALT} st_t;
  st_t st;

  logic [AW-1:0] dptr, sa, da, nxt;
  logic [2:0]    idx;
  logic [7:0]    soff, doff, bw, wcnt;
  logic [14:0]   biter, citer;
  logic          sg, dreq, self_go, pend;
  logic [31:0]   buf_q;

  wire [7:0]    bw_n      = (bw == 8'd0) ? DEFW : bw;
  wire          last_word = (wcnt == bw_n - 8'd1);
  wire          req_hit   = req & req_en;
  wire [AW-1:0] soffx     = {{(AW-8){soff[7]}}, soff};
  wire [AW-1:0] doffx     = {{(AW-8){doff[7]}}, doff};
  wire          bad       = (|{sa[1:0], da[1:0], soff[1:0], doff[1:0]}) || (biter == 15'd0);
  wire          major_end = (st == WR) && mem_ack && !mem_err && last_word && (citer == 15'd1);
  wire          take      = pend | req_hit;

  assign mem_req   = (st == FETCH) || (st == RD) || (st == WR);
  assign mem_we    = (st == WR);
  assign mem_addr  = (st == FETCH) ? dptr + {{(AW-5){1'b0}}, idx, 2'b00} :
                     (st == RD)    ? sa : da;
  assign mem_wdata = buf_q;
  assign active    = (st == FETCH) || (st == CHECK) || (st == RD) || (st == WR);
  assign iter_left = citer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; idx <= '0; dptr <= '0; sa <= '0; da <= '0; nxt <= '0;
      soff <= '0; doff <= '0; bw <= '0; wcnt <= '0; biter <= '0; citer <= '0;
      sg <= 1'b0; dreq <= 1'b0; self_go <= 1'b0; pend <= 1'b0; buf_q <= '0;
      done <= 1'b0; err <= 1'b0; err_addr <= '0; req_en <= 1'b0;
    end else begin
      if (req_en_set) req_en <= 1'b1;
      pend <= pend | req_hit;
      case (st)
        IDLE, ARMED: begin
          if (load) begin
            dptr <= load_addr; idx <= '0; done <= 1'b0; st <= FETCH;
          end else if (st == ARMED && take) begin
            wcnt <= '0; st <= RD; pend <= pend & req_hit;
          end
        end
        FETCH: begin
          if (mem_err) begin
            err <= 1'b1; err_addr <= mem_addr; st <= HALT;
          end else if (mem_ack) begin
            case (idx)
              3'd0: sa <= mem_rdata[AW-1:0];
              3'd1: da <= mem_rdata[AW-1:0];
              3'd2: begin soff <= mem_rdata[7:0]; doff <= mem_rdata[15:8]; bw <= mem_rdata[23:16]; end
              3'd3: begin biter <= mem_rdata[14:0]; sg <= mem_rdata[15]; dreq <= mem_rdata[16]; self_go <= mem_rdata[17]; end
              default: nxt <= mem_rdata[AW-1:0];
            endcase
            if (idx == 3'd4) st <= CHECK;
            else idx <= idx + 3'd1;
          end
        end
        CHECK: begin
          if (bad) begin
            err <= 1'b1; err_addr <= dptr; st <= HALT;
          end else begin
            citer <= biter; wcnt <= '0; st <= self_go ? RD : ARMED;
          end
        end
        RD: begin
          if (mem_err) begin
            err <= 1'b1; err_addr <= mem_addr; st <= HALT;
          end else if (mem_ack) begin
            buf_q <= mem_rdata; sa <= sa + soffx; st <= WR;
          end
        end
        WR: begin
          if (mem_err) begin
            err <= 1'b1; err_addr <= mem_addr; st <= HALT;
          end else if (mem_ack) begin
            da <= da + doffx;
            if (!last_word) begin
              wcnt <= wcnt + 8'd1; st <= RD;
            end else begin
              wcnt <= '0;
              if (citer == 15'd1) begin
                done <= 1'b1; citer <= biter;
                if (sg) begin dptr <= nxt; idx <= '0; st <= FETCH; end
                else st <= self_go ? IDLE : ARMED;
              end else begin
                citer <= citer - 15'd1; st <= self_go ? RD : ARMED;
              end
            end
          end
        end
        default: begin
          if (err_clr) begin err <= 1'b0; err_addr <= '0; st <= IDLE; end
        end
      endcase
      if (req_en_clr || (major_end && dreq)) begin
        req_en <= 1'b0; pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic          mem_err,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          err,
  input logic [AW-1:0] err_addr,
  input logic          req_en,
  input logic [14:0]   iter_left,
  input logic          pend,
  input logic [14:0]   biter
);
  assert_err_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_req);

  assert_err_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err && $past(err) |-> $stable(err_addr));

  assert_no_pend_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_en |-> !pend);

  assert_reload_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> iter_left == biter);

  assert_iter_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_req && mem_we && mem_ack && !mem_err) && (iter_left != $past(iter_left))
    |-> (iter_left == $past(iter_left) - 15'd1) || ($past(iter_left) == 15'd1 && iter_left == biter));

  assert_access_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_err(mem_err), .mem_addr(mem_addr), .done(done), .err(err), .err_addr(err_addr),
  .req_en(req_en), .iter_left(iter_left), .pend(pend), .biter(biter)
);

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;
  localparam logic [31:0] PERIPH = 32'h0000_1000;
  localparam logic [31:0] BAD    = 32'h0000_0FF0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        load = 1'b0, req_en_set = 1'b0, req_en_clr = 1'b0, req = 1'b0, err_clr = 1'b0;
  logic [31:0] load_addr = '0;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, err_addr;
  logic        active, done, err, req_en;
  logic [14:0] iter_left;

  dma_chan_engine u_dma_chan_engine (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
    .req_en_set(req_en_set), .req_en_clr(req_en_clr), .req(req), .err_clr(err_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .active(active), .done(done), .err(err), .err_addr(err_addr),
    .req_en(req_en), .iter_left(iter_left)
  );

  int compared = 0, mism = 0, gcount = 0, cyc = 0;
  string cur_tag = "R1";
  logic [31:0] mem [0:1023];
  logic [31:0] sh  [0:1023];
  logic [31:0] qa[$], qd[$];
  bit          qw[$];
  logic [31:0] pcnt = 32'hC0DE_0000, pm = 32'hC0DE_0000;
  logic [31:0] exp_err_addr = '0;

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0101_0101) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mism++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] v);
    mem[a[11:2]] = v; sh[a[11:2]] = v;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] d,
                          input logic [7:0] so, input logic [7:0] dof, input logic [7:0] bw,
                          input logic [14:0] it, input bit sg, input bit dq, input bit go,
                          input logic [31:0] nx);
    poke(a, s); poke(a + 4, d);
    poke(a + 8, {8'h00, bw, dof, so});
    poke(a + 12, {14'b0, go, dq, sg, it});
    poke(a + 16, nx);
  endtask

  task automatic push(input logic [31:0] a, input bit w, input logic [31:0] d);
    qa.push_back(a); qw.push_back(w); qd.push_back(d);
  endtask

  // Behavioural reference: predicts the ordered stream of memory accesses.
  task automatic model(input logic [31:0] dp0);
    logic [31:0] dp, s, d, v;
    logic [31:0] w [5];
    int so, dof, bw, it;
    dp = dp0;
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 5; k++) begin
        push(dp + 32'(4 * k), 1'b0, '0);
        w[k] = sh[(dp[11:2]) + 10'(k)];
      end
      s = w[0]; d = w[1];
      so = int'($signed(w[2][7:0])); dof = int'($signed(w[2][15:8]));
      bw = (w[2][23:16] == 8'd0) ? 16 : int'(w[2][23:16]);
      it = int'(w[3][14:0]);
      if (s[1:0] != 0 || d[1:0] != 0 || so % 4 != 0 || dof % 4 != 0 || it == 0) begin
        exp_err_addr = dp; return;
      end
      for (int i = 0; i < it; i++) begin
        for (int j = 0; j < bw; j++) begin
          push(s, 1'b0, '0);
          if (s == BAD) begin exp_err_addr = s; return; end
          if (s == PERIPH) begin v = pm; pm = pm + 1; end
          else v = sh[s[11:2]];
          push(d, 1'b1, v);
          if (d == BAD) begin exp_err_addr = d; return; end
          if (d != PERIPH) sh[d[11:2]] = v;
          s = s + 32'(so); d = d + 32'(dof);
        end
      end
      if (!w[3][15]) return;
      dp = w[4];
    end
  endtask

  // Memory and peripheral responder, with wait states and one error address.
  initial begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
      if (rst_n && mem_req && (cyc % 4) != 3) begin
        gcount++;
        if (qa.size() == 0) begin
          compared++; mism++;
          $display("FAIL %s unexpected access actual=%h expected=none", cur_tag, mem_addr);
        end else begin
          chk({cur_tag, " addr"}, mem_addr, qa[0]);
          chk({cur_tag, " dir"}, {31'b0, mem_we}, {31'b0, qw[0]});
          if (qw[0]) chk({cur_tag, " data"}, mem_wdata, qd[0]);
          void'(qa.pop_front()); void'(qw.pop_front()); void'(qd.pop_front());
        end
        if (mem_addr == BAD) mem_err = 1'b1;
        else begin
          mem_ack = 1'b1;
          if (mem_we) begin
            if (mem_addr != PERIPH) mem[mem_addr[11:2]] = mem_wdata;
          end else if (mem_addr == PERIPH) begin
            mem_rdata = pcnt; pcnt = pcnt + 1;
          end else mem_rdata = mem[mem_addr[11:2]];
        end
      end
    end
  end

  task automatic do_load(input logic [31:0] a);
    @(negedge clk); load = 1'b1; load_addr = a;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: req = 1'b1;
      1: req_en_set = 1'b1;
      2: req_en_clr = 1'b1;
      default: err_clr = 1'b1;
    endcase
    @(negedge clk);
    req = 1'b0; req_en_set = 1'b0; req_en_clr = 1'b0; err_clr = 1'b0;
  endtask

  task automatic wait_quiet();
    int n;
    n = 0;
    while ((qa.size() != 0 || active) && !err && n < 30000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mism++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

  initial begin
    int g0;
    for (int i = 0; i < 1024; i++) begin mem[i] = pat(i); sh[i] = pat(i); end
    repeat (3) @(negedge clk);
    chk("R1 mem_req in reset", {31'b0, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", {31'b0, done}, 0);
    chk("R1 err", {31'b0, err}, 0);
    chk("R1 req_en", {31'b0, req_en}, 0);
    chk("R1 active", {31'b0, active}, 0);
    chk("R1 iter_left", {17'b0, iter_left}, 0);

    // R6 R4: software start, default 16-word burst
    cur_tag = "R6";
    put_desc(32'hE00, 32'h500, 32'h600, 8'd4, 8'd4, 8'd0, 15'd1, 0, 0, 1, 0);
    model(32'hE00);
    do_load(32'hE00);
    wait_quiet();
    chk("R6 queue drained", qa.size(), 0);
    chk("R5 done", {31'b0, done}, 1);
    chk("R5 iter reload", {17'b0, iter_left}, 1);
    chk("R4 default burst word", mem[32'h63C >> 2], pat(32'h53C >> 2));

    // R10 R3: chained descriptors, the second walking downward
    cur_tag = "R10";
    put_desc(32'hE40, 32'h100, 32'h300, 8'd4, 8'd4, 8'd2, 15'd3, 1, 0, 1, 32'hE80);
    put_desc(32'hE80, 32'h13C, 32'h43C, 8'hFC, 8'hFC, 8'd4, 15'd4, 0, 0, 1, 0);
    model(32'hE40);
    do_load(32'hE40);
    chk("R2 done cleared by load", {31'b0, done}, 0);
    wait_quiet();
    chk("R10 queue drained", qa.size(), 0);
    chk("R10 done", {31'b0, done}, 1);
    chk("R10 second count", {17'b0, iter_left}, 4);
    chk("R3 negative offset word", mem[32'h400 >> 2], pat(32'h100 >> 2));

    // R5 R2: count 513 uses both count fields; fixed peripheral destination
    cur_tag = "R3";
    put_desc(32'hEC0, 32'h000, PERIPH, 8'd4, 8'd0, 8'd1, 15'd513, 0, 0, 1, 0);
    model(32'hEC0);
    do_load(32'hEC0);
    wait_quiet();
    chk("R3 queue drained", qa.size(), 0);
    chk("R5 done 513", {31'b0, done}, 1);
    chk("R2 split count", {17'b0, iter_left}, 513);

    // R7 R8 R9: paced peripheral-to-memory, drop enable on completion
    cur_tag = "R7";
    put_desc(32'hF00, PERIPH, 32'h200, 8'd0, 8'd4, 8'd0, 15'd2, 0, 1, 0, 0);
    model(32'hF00);
    do_load(32'hF00);
    repeat (20) @(negedge clk);
    chk("R7 armed idle", {31'b0, active}, 0);
    chk("R2 count loaded", {17'b0, iter_left}, 2);
    g0 = gcount;
    pulse(0);
    repeat (10) @(negedge clk);
    chk("R7 request ignored when disabled", gcount, g0);
    chk("R7 count unchanged", {17'b0, iter_left}, 2);
    pulse(1);
    chk("R7 req_en set", {31'b0, req_en}, 1);
    pulse(0);
    repeat (6) @(negedge clk);
    cur_tag = "R8";
    pulse(0);
    repeat (3) @(negedge clk);
    chk("R4 no decrement mid-loop", {17'b0, iter_left}, 2);
    wait_quiet();
    chk("R8 pending served", qa.size(), 0);
    chk("R5 done paced", {31'b0, done}, 1);
    chk("R9 req_en dropped", {31'b0, req_en}, 0);
    g0 = gcount;
    pulse(0);
    repeat (10) @(negedge clk);
    chk("R9 later request ignored", gcount, g0);

    // R9 R7: drop-enable clear keeps enable; clear port then blocks requests
    cur_tag = "R9";
    put_desc(32'hF40, 32'h700, PERIPH, 8'd4, 8'd0, 8'd1, 15'd1, 0, 0, 0, 0);
    model(32'hF40);
    do_load(32'hF40);
    repeat (20) @(negedge clk);
    pulse(1);
    pulse(0);
    wait_quiet();
    chk("R9 queue drained", qa.size(), 0);
    chk("R9 req_en kept", {31'b0, req_en}, 1);
    pulse(2);
    chk("R7 req_en cleared", {31'b0, req_en}, 0);
    g0 = gcount;
    pulse(0);
    repeat (10) @(negedge clk);
    chk("R7 request after clear ignored", gcount, g0);

    // R11: misaligned destination rejected
    cur_tag = "R11";
    put_desc(32'hF80, 32'h800, 32'h202, 8'd4, 8'd4, 8'd1, 15'd1, 0, 0, 1, 0);
    model(32'hF80);
    do_load(32'hF80);
    wait_quiet();
    chk("R11 only fetch", qa.size(), 0);
    chk("R11 err", {31'b0, err}, 1);
    chk("R11 err_addr", err_addr, exp_err_addr);
    g0 = gcount;
    do_load(32'hE00);
    repeat (8) @(negedge clk);
    chk("R12 load ignored in error", gcount, g0);
    pulse(3);
    chk("R12 err cleared", {31'b0, err}, 0);
    chk("R12 err_addr cleared", err_addr, 0);

    // R12: bus error in mid-burst
    cur_tag = "R12";
    put_desc(32'hFC0, 32'hFE8, 32'h900, 8'd4, 8'd4, 8'd4, 15'd1, 0, 0, 1, 0);
    model(32'hFC0);
    do_load(32'hFC0);
    wait_quiet();
    chk("R12 stream up to error", qa.size(), 0);
    chk("R12 err", {31'b0, err}, 1);
    chk("R12 err_addr", err_addr, BAD);
    chk("R12 count held", {17'b0, iter_left}, 1);
    chk("R12 no request while halted", {31'b0, mem_req}, 0);
    pulse(3);
    chk("R12 cleared", {31'b0, err}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end
endmodule